// File: doc/BRIEF.md
# Timer Compare Output Unit

This unit watches a free-running timer and reacts when the timer reaches a programmable 16-bit compare value. A 4-bit mode field sets the reaction: the unit drives its output latch high or low, flips it, leaves it alone and only raises an interrupt flag, or issues a special event. A special event clears the timer, which turns the compare value into a timer period, and can also request the start of an analog-to-digital conversion.

Software programs the mode and the compare value through a simple write port and clears the interrupt flag with a strobe. The timer and the converter sit outside the unit. The unit receives the timer value and returns a one-cycle timer-clear strobe and a conversion-start strobe. The output latch reaches the pin only when the direction configuration selects output.

Top module: `cmp_channel`

## Requirements
- R1: After reset, the mode is 0000, the output latch is low, the interrupt flag is low, and timerClr and convStart are low.
- R2: A match is the first cycle in which timerVal equals the compare register. Either the timer advancing or a compare write can create it. One equality produces one action, even if the timer stays at that value.
- R3: Mode 1000: a match drives the latch high at the clock edge that ends the match cycle.
- R4: Mode 1001: a match drives the latch low at that edge.
- R5: Mode 0010: a match inverts the latch at that edge.
- R6: Mode 1010: a match leaves the latch unchanged and only sets the interrupt flag.
- R7: In modes 1000, 1001, 0010, 1010 and 1011, a match sets intFlag at the same edge as the latch action. The flag stays set until a flagClr. When a flagClr and a match coincide, the flag stays set.
- R8: Mode 1011: during the match cycle, timerClr is high for that one cycle and the latch is unchanged. With a timer that clears on timerClr, the period is the compare value plus one, and the timer never wraps.
- R9: In mode 1011, convStart pulses together with timerClr when convEnable is high and the parameter CONV_TRIG is 1. Otherwise convStart stays low.
- R10: Writing mode 0000 forces the latch low at that edge. This overrides any match action in the same cycle.
- R11: Mode 0000 and all codes not listed above take no match action and never set the flag.
- R12: pinOe follows outEnCfg. pinOut shows the latch when outEnCfg is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrModeEn | input | 1 | Write strobe for the mode field |
| wrModeData | input | 4 | New mode value |
| wrCmpEn | input | 1 | Write strobe for the compare register |
| wrCmpData | input | 16 | New compare value |
| flagClr | input | 1 | Clears the interrupt flag |
| timerVal | input | 16 | Current timer value |
| outEnCfg | input | 1 | Direction configuration (1 = output) |
| convEnable | input | 1 | Converter enabled |
| timerClr | output | 1 | Timer clear request (special event) |
| convStart | output | 1 | Conversion start request |
| pinOut | output | 1 | Pin data |
| pinOe | output | 1 | Pin output enable |
| intFlag | output | 1 | Compare interrupt flag |

## Verification
The timer passes through the compare value in each mode. This shows that each action lands on the right edge and in the right direction, and that toggling actually inverts. Holding the timer at the compare value, and writing a compare value equal to a held timer, separate true edge detection from level detection. Letting the special event reload the timer measures the period directly. Collisions of a flag clear or a zero-mode write with a match cycle test the two priority rules. An unlisted code and a disabled output direction show that the latch state is not disturbed by unlisted codes and is hidden at the pin when the output direction is disabled.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF = 4'b0000,
    MODE_SET = 4'b1000,
    MODE_CLR = 4'b1001,
    MODE_TGL = 4'b0010,
    MODE_IRQ = 4'b1010,
    MODE_EVT = 4'b1011
  } cmpMode_e;

  typedef struct packed {
    logic forceLow;
    logic drvHigh;
    logic drvLow;
    logic flip;
    logic raiseFlag;
  } cmpStrobe_t;
endpackage

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_pkg::*;
#(
  parameter bit CONV_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrModeEn,
  input  logic [MODE_W-1:0] wrModeData,
  input  logic              matchEdge,
  input  logic              convEnable,
  output logic [MODE_W-1:0] modeQ,
  output cmpStrobe_t        strobes,
  output logic              timerClr,
  output logic              convStart
);
  logic evtHit;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_OFF;
    else if (wrModeEn) modeQ <= wrModeData;
  end

  always_comb begin
    strobes = '0;
    evtHit = 1'b0;
    strobes.forceLow = wrModeEn && (wrModeData == MODE_OFF);
    if (matchEdge) begin
      case (modeQ)
        MODE_SET: begin strobes.drvHigh = 1'b1; strobes.raiseFlag = 1'b1; end
        MODE_CLR: begin strobes.drvLow = 1'b1; strobes.raiseFlag = 1'b1; end
        MODE_TGL: begin strobes.flip = 1'b1; strobes.raiseFlag = 1'b1; end
        MODE_IRQ: strobes.raiseFlag = 1'b1;
        MODE_EVT: begin strobes.raiseFlag = 1'b1; evtHit = 1'b1; end
        default: ;
      endcase
    end
  end

  assign timerClr = evtHit;

  generate
    if (CONV_TRIG) begin : g_conv
      assign convStart = evtHit && convEnable;
    end else begin : g_noConv
      logic unusedEn;
      assign unusedEn = convEnable;
      assign convStart = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCmpEn,
  input  logic [WIDTH-1:0] wrCmpData,
  input  logic [WIDTH-1:0] timerVal,
  input  logic             flagClr,
  input  logic             outEnCfg,
  input  cmpStrobe_t       strobes,
  output logic             matchEdge,
  output logic             latchQ,
  output logic             intFlag,
  output logic             pinOut,
  output logic             pinOe
);
  logic [WIDTH-1:0] cmpQ;
  logic             eqPrevQ;
  logic             eqNow;

  assign eqNow     = (timerVal == cmpQ);
  assign matchEdge = eqNow && !eqPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ    <= '0;
      eqPrevQ <= 1'b0;
    end else begin
      if (wrCmpEn) cmpQ <= wrCmpData;
      eqPrevQ <= eqNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                latchQ <= 1'b0;
    else if (strobes.forceLow) latchQ <= 1'b0;
    else if (strobes.drvHigh)  latchQ <= 1'b1;
    else if (strobes.drvLow)   latchQ <= 1'b0;
    else if (strobes.flip)     latchQ <= !latchQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  intFlag <= 1'b0;
    else if (strobes.raiseFlag) intFlag <= 1'b1;
    else if (flagClr)           intFlag <= 1'b0;
  end

  assign pinOe  = outEnCfg;
  assign pinOut = outEnCfg & latchQ;
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter bit CONV_TRIG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrModeEn,
  input  logic [3:0]       wrModeData,
  input  logic             wrCmpEn,
  input  logic [WIDTH-1:0] wrCmpData,
  input  logic             flagClr,
  input  logic [WIDTH-1:0] timerVal,
  input  logic             outEnCfg,
  input  logic             convEnable,
  output logic             timerClr,
  output logic             convStart,
  output logic             pinOut,
  output logic             pinOe,
  output logic             intFlag
);
  cmpStrobe_t        strobes;
  logic              matchEdge;
  logic [MODE_W-1:0] modeQ;
  logic              latchQ;

  cmp_ctrl #(.CONV_TRIG(CONV_TRIG)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrModeEn(wrModeEn), .wrModeData(wrModeData),
    .matchEdge(matchEdge), .convEnable(convEnable), .modeQ(modeQ),
    .strobes(strobes), .timerClr(timerClr), .convStart(convStart)
  );

  cmp_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .wrCmpEn(wrCmpEn), .wrCmpData(wrCmpData),
    .timerVal(timerVal), .flagClr(flagClr), .outEnCfg(outEnCfg),
    .strobes(strobes), .matchEdge(matchEdge), .latchQ(latchQ),
    .intFlag(intFlag), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/cmp_channel_checker.sv
module cmp_channel_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] modeQ,
  input logic       latchQ,
  input logic       intFlag,
  input logic       flagClr,
  input logic       timerClr,
  input logic       convStart,
  input logic       pinOut,
  input logic       pinOe,
  input logic       wrModeEn,
  input logic [3:0] wrModeData
);
  p_evt_mode_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    timerClr |-> (modeQ == 4'b1011));

  p_flag_after_evt_r7: assert property (@(posedge clk) disable iff (!rstN)
    timerClr |=> intFlag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !flagClr) |=> intFlag);

  p_conv_with_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> timerClr);

  p_zero_write_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrModeEn && wrModeData == 4'b0000) |=> !latchQ);

  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 4'b0000) |-> (!timerClr && !convStart));

  p_pin_gated_r12: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe |-> !pinOut);
endmodule

bind cmp_channel cmp_channel_checker u_chk (
  .clk(clk), .rstN(rstN), .modeQ(modeQ), .latchQ(latchQ), .intFlag(intFlag),
  .flagClr(flagClr), .timerClr(timerClr), .convStart(convStart),
  .pinOut(pinOut), .pinOe(pinOe), .wrModeEn(wrModeEn), .wrModeData(wrModeData)
);

// File: tb/cmp_channel_bench.sv
`timescale 1ns/1ps
module cmp_channel_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrModeEn = 1'b0;
  logic [3:0]  wrModeData = 4'd0;
  logic        wrCmpEn = 1'b0;
  logic [15:0] wrCmpData = 16'd0;
  logic        flagClr = 1'b0;
  logic [15:0] timerCnt = 16'd0;
  logic        outEnCfg = 1'b1;
  logic        convEnable = 1'b0;
  logic        timerClr, convStart, pinOut, pinOe, intFlag;

  int nChk = 0;
  int nFail = 0;
  bit timerHold = 1'b0;
  bit ovfFlag = 1'b0;
  int tickNo = 0;
  int lastClr = -1;
  int period = 0;
  int convSeen = 0;

  // behavioural reference state
  logic [3:0]  mMode = 4'd0;
  logic [15:0] mCmp = 16'd0;
  bit mEq = 1'b0, mLatch = 1'b0, mFlag = 1'b0;

  always #5 clk = ~clk;

  cmp_channel u_cmp_channel (
    .clk(clk), .rstN(rstN), .wrModeEn(wrModeEn), .wrModeData(wrModeData),
    .wrCmpEn(wrCmpEn), .wrCmpData(wrCmpData), .flagClr(flagClr),
    .timerVal(timerCnt), .outEnCfg(outEnCfg), .convEnable(convEnable),
    .timerClr(timerClr), .convStart(convStart), .pinOut(pinOut),
    .pinOe(pinOe), .intFlag(intFlag)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: compare outputs with the model, then advance model and timer stub
  task automatic tick();
    bit hit, eClr, nLatch, nFlag;
    logic [15:0] nTimer;
    #1;
    hit  = (timerCnt == mCmp) && !mEq;
    eClr = hit && (mMode == 4'b1011);
    chk("R8", "timerClr", timerClr, eClr);
    chk("R9", "convStart", convStart, eClr && convEnable);
    chk("R12", "pinOe", pinOe, outEnCfg);
    chk("R12", "pinOut", pinOut, outEnCfg & mLatch);
    chk("R7", "intFlag", intFlag, mFlag);
    if (timerClr) begin
      if (lastClr >= 0) period = tickNo - lastClr;
      lastClr = tickNo;
    end
    if (convStart) convSeen++;
    nLatch = mLatch;
    if (hit) begin
      if (mMode == 4'b1000) nLatch = 1'b1;
      else if (mMode == 4'b1001) nLatch = 1'b0;
      else if (mMode == 4'b0010) nLatch = !mLatch;
    end
    if (wrModeEn && wrModeData == 4'd0) nLatch = 1'b0;
    nFlag = mFlag;
    if (flagClr) nFlag = 1'b0;
    if (hit && (mMode inside {4'b1000, 4'b1001, 4'b0010, 4'b1010, 4'b1011})) nFlag = 1'b1;
    if (timerClr) nTimer = 16'd0;
    else if (timerHold) nTimer = timerCnt;
    else begin
      nTimer = timerCnt + 16'd1;
      if (timerCnt == 16'hFFFF) ovfFlag = 1'b1;
    end
    @(posedge clk);
    mEq = (timerCnt == mCmp);
    mLatch = nLatch;
    mFlag = nFlag;
    if (wrModeEn) mMode = wrModeData;
    if (wrCmpEn) mCmp = wrCmpData;
    timerCnt <= nTimer;
    tickNo++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic writeMode(input logic [3:0] v);
    wrModeEn = 1'b1; wrModeData = v;
    tick();
    wrModeEn = 1'b0;
  endtask

  task automatic writeCmp(input logic [15:0] v);
    wrCmpEn = 1'b1; wrCmpData = v;
    tick();
    wrCmpEn = 1'b0;
  endtask

  task automatic setTimer(input logic [15:0] v);
    timerCnt <= v;
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    timerHold = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "intFlag", intFlag, 0);
    chk("R1", "pinOut", pinOut, 0);
    chk("R1", "timerClr", timerClr, 0);
    chk("R1", "convStart", convStart, 0);
    timerHold = 1'b0;

    // R3 set on match
    writeCmp(16'd20);
    setTimer(16'd0);
    writeMode(4'b1000);
    run(25);
    chk("R3", "pinOut after set match", pinOut, 1);
    chk("R7", "flag after match", intFlag, 1);
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    chk("R7", "flag after clear", intFlag, 0);

    // R10 zero write clears latch
    writeMode(4'b0000);
    chk("R10", "pinOut after off", pinOut, 0);

    // R2 held timer toggles only once
    writeMode(4'b0010);
    timerHold = 1'b1;
    setTimer(16'd20);
    run(6);
    chk("R2", "toggle once when held", pinOut, 1);
    timerHold = 1'b0;

    // R5 toggle again
    setTimer(16'd15);
    run(10);
    chk("R5", "second toggle", pinOut, 0);

    // R4 clear on match
    writeMode(4'b1000);
    setTimer(16'd15); run(10);
    writeMode(4'b1001);
    setTimer(16'd15); run(10);
    chk("R4", "pinOut after clear match", pinOut, 0);

    // R6 interrupt only keeps latch
    writeMode(4'b1000);
    setTimer(16'd15); run(10);
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    writeMode(4'b1010);
    setTimer(16'd15); run(10);
    chk("R6", "latch kept", pinOut, 1);
    chk("R6", "flag raised", intFlag, 1);

    // R11 unlisted code
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    writeMode(4'b0101);
    setTimer(16'd15); run(10);
    chk("R11", "no flag", intFlag, 0);
    chk("R11", "latch kept", pinOut, 1);

    // R8 special event period
    writeCmp(16'd9);
    writeMode(4'b1011);
    ovfFlag = 1'b0; lastClr = -1;
    setTimer(16'd0);
    run(45);
    chk("R8", "period", period, 10);
    chk("R8", "no wrap", ovfFlag, 0);
    chk("R8", "latch kept", pinOut, 1);

    // R9 conversion start
    convEnable = 1'b1; convSeen = 0;
    run(22);
    chk("R9", "conv pulses", convSeen, 2);
    convEnable = 1'b0;

    // R7 clear colliding with match
    for (int i = 0; i < 12 && timerCnt != 16'd9; i++) tick();
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    chk("R7", "match beats clear", intFlag, 1);

    // R10 zero write colliding with set match
    writeMode(4'b0000);
    writeMode(4'b1000);
    timerHold = 1'b1;
    setTimer(16'd8); tick();
    setTimer(16'd9);
    writeMode(4'b0000);
    chk("R10", "zero write beats match", pinOut, 0);

    // R2 compare write onto held timer
    writeMode(4'b0010);
    setTimer(16'd100); tick();
    writeCmp(16'd100);
    run(3);
    chk("R2", "compare write makes match", pinOut, 1);

    // R12 direction gating
    outEnCfg = 1'b0; tick();
    chk("R12", "pin gated", pinOut, 0);
    chk("R12", "oe low", pinOe, 0);
    outEnCfg = 1'b1; tick();
    chk("R12", "pin shows latch", pinOut, 1);

    summary();
    $finish;
  end
endmodule